// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block multiplies two operands and folds the product into a 48-bit accumulator. A new operand pair can be presented on every clock. Each operand is 16 or 32 bits wide and is read as a signed integer, an unsigned integer or a signed fixed-point fraction. The product is first reduced to 40 bits. Integer formats keep the low-order bits. The fractional format removes the duplicated sign bit and takes the upper 40 bits, either truncated or rounded to nearest with ties to even. The 40-bit value is then widened to 48 bits, can be scaled by one bit position in either direction, and is added to or subtracted from the accumulator. The sum either wraps or saturates.

The block has two pipeline stages. The first registers the full 64-bit product together with the mode fields that came with it. The second forms the reduced, extended and scaled product and updates the accumulator. A software-visible load port writes the accumulator directly, and a clear input zeroes it. An overflow flag records any overflow of the accumulator and stays set until the next clear.

Top module: `mac_pipe`

## Requirements
- R1: An operand pair is accepted on every rising edge where `inValid` is high. Its contribution is visible on `accOut` after the next rising edge, and `accValid` is high for exactly that one cycle. Back-to-back pairs accumulate with no gaps.
- R2: When `opWide`=0, only bits [15:0] of each operand are used. They are sign-extended for the signed integer format, zero-extended for the unsigned format, and placed in bits [31:16] with zeros below for the fraction format.
- R3: For `opFmt`=2'b00 (signed integer; 2'b11 behaves the same) and `opFmt`=2'b01 (unsigned integer), the 40-bit product is bits [39:0] of the exact product.
- R4: For `opFmt`=2'b10 (fraction) with `roundEn`=0, the 40-bit product is bits [63:24] of the 64-bit product shifted left by one.
- R5: For the fraction format with `roundEn`=1, those same bits are rounded to nearest using the 24 discarded bits. An exact half rounds to the even value.
- R6: The 40-bit product is sign-extended to 48 bits for the signed and fraction formats, and zero-extended for the unsigned format.
- R7: `prodShift` scales the 48-bit product before accumulation. 2'b01 shifts it left by one, dropping the top bit. 2'b10 shifts it right by one, arithmetically for the signed and fraction formats and logically for the unsigned format. 2'b00 and 2'b11 leave it unchanged.
- R8: With `subEn`=0 the product is added to the accumulator. With `subEn`=1 it is subtracted.
- R9: With `satEn`=1, an overflowing result is clamped. In the signed and fraction formats it becomes 48'h7FFF_FFFF_FFFF or 48'h8000_0000_0000. In the unsigned format it becomes all ones on an add and zero on a subtract.
- R10: With `satEn`=0, the result wraps modulo 2^48.
- R11: `ovfFlag` is set by any accumulation that overflows, whether or not saturation is on. It stays set until `clearEn` is sampled high, which drops it on the next edge.
- R12: A `clearEn` sampled on an edge zeroes the accumulator. Otherwise a `loadEn` writes `loadVal`. Either one overrides an accumulation due on that same edge, which is then lost, and `accValid` stays low.
- R13: During and after reset, `accOut`, `ovfFlag` and `accValid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand pair present this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opFmt | input | 2 | 00 signed int, 01 unsigned int, 10 fraction, 11 signed int |
| opWide | input | 1 | 1: 32-bit operands, 0: 16-bit operands in bits [15:0] |
| roundEn | input | 1 | Fraction reduction rounds (1) or truncates (0) |
| prodShift | input | 2 | 00 none, 01 left by one, 10 right by one, 11 none |
| subEn | input | 1 | Subtract the product instead of adding it |
| satEn | input | 1 | Clamp on overflow instead of wrapping |
| loadEn | input | 1 | Write `loadVal` into the accumulator |
| loadVal | input | 48 | Value for a load |
| clearEn | input | 1 | Zero the accumulator and the overflow flag |
| accOut | output | 48 | Accumulator contents |
| accValid | output | 1 | Accumulator was updated by an operand pair at the last edge |
| ovfFlag | output | 1 | Sticky overflow indicator |

## Verification
On every cycle the assertions check that the accumulator control behaves correctly. A clear or load lands on the next edge with the right priority. The accumulator holds when nothing is due. The overflow flag persists until a clear drops it. `accValid` follows an accepted pair by exactly two edges. The arithmetic itself can only be shown by the bench scenarios. These cover reduction and rounding per format, operand narrowing, extension and scaling, add versus subtract, and clamping versus wrapping. The bench sweeps a grid of corner operand values and accumulator seeds across every mode combination and compares each result with values it computes by plain integer arithmetic.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    FMT_SINT = 2'b00,
    FMT_UINT = 2'b01,
    FMT_FRAC = 2'b10,
    FMT_ALT  = 2'b11
  } fmtT;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_KEEP  = 2'b11
  } shiftT;

  typedef struct packed {
    logic capture;
    logic accumulate;
    logic load;
    logic clear;
  } strobeT;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   loadEn,
  input  logic   clearEn,
  input  logic   ovfDet,
  output strobeT strobes,
  output logic   accValid,
  output logic   ovfFlag
);

  logic stg1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg1Valid <= 1'b0;
    else       stg1Valid <= inValid;
  end

  always_comb begin
    strobes.capture    = inValid;
    strobes.clear      = clearEn;
    strobes.load       = loadEn & ~clearEn;
    strobes.accumulate = stg1Valid & ~loadEn & ~clearEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accValid <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      accValid <= strobes.accumulate;
      if (clearEn)
        ovfFlag <= 1'b0;
      else if (strobes.accumulate && ovfDet)
        ovfFlag <= 1'b1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $past(inValid, 2)); // R1

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clearEn) |=> ovfFlag); // R11

  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    clearEn |=> !ovfFlag); // R11

  AST_OVERRIDE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn || clearEn) |=> !accValid); // R12

endmodule

// File: rtl/mac_reduce.sv
module mac_reduce
  import mac_pkg::*;
#(
  parameter int PROD_FULL = 64,
  parameter int PROD_W    = 40,
  parameter int ACC_W     = 48
) (
  input  logic [PROD_FULL-1:0] prod,
  input  fmtT                  fmt,
  input  logic                 rnd,
  input  shiftT                shf,
  output logic [ACC_W-1:0]     scaled
);

  localparam int DROP = PROD_FULL - PROD_W;
  localparam int PAD  = ACC_W - PROD_W;
  localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

  logic                 isUns;
  logic                 isFrac;
  logic [PROD_FULL-1:0] fracAligned;
  logic [PROD_W-1:0]    hiPart;
  logic [DROP-1:0]      loPart;
  logic                 roundUp;
  logic [PROD_W-1:0]    fracVal;
  logic [PROD_W-1:0]    narrowProd;
  logic [ACC_W-1:0]     widened;
  logic                 fillBit;

  always_comb begin
    isUns       = (fmt == FMT_UINT);
    isFrac      = (fmt == FMT_FRAC);
    fracAligned = prod << 1;
    hiPart      = fracAligned[PROD_FULL-1 -: PROD_W];
    loPart      = fracAligned[DROP-1:0];
    roundUp     = rnd && ((loPart > HALF) || ((loPart == HALF) && hiPart[0]));
    fracVal     = hiPart + {{(PROD_W-1){1'b0}}, roundUp};
    narrowProd  = isFrac ? fracVal : fracAligned[PROD_W:1];
  end

  always_comb begin
    fillBit = isUns ? 1'b0 : narrowProd[PROD_W-1];
    widened = {{PAD{fillBit}}, narrowProd};
    unique case (shf)
      SH_LEFT:  scaled = {widened[ACC_W-2:0], 1'b0};
      SH_RIGHT: scaled = {(isUns ? 1'b0 : widened[ACC_W-1]), widened[ACC_W-1:1]};
      default:  scaled = widened;
    endcase
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W     = 32,
  parameter int NARROW_W = 16,
  parameter int PROD_W   = 40,
  parameter int ACC_W    = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  fmtT              fmt,
  input  logic             wide,
  input  logic             rnd,
  input  shiftT            shf,
  input  logic             sub,
  input  logic             sat,
  input  logic [ACC_W-1:0] loadVal,
  output logic [ACC_W-1:0] accOut,
  output logic             ovfDet
);

  localparam int PROD_FULL = 2 * OP_W;
  localparam int GAP       = OP_W - NARROW_W;
  localparam int SUM_W     = ACC_W + 1;

  // operand conditioning
  logic signed [OP_W:0] mulA;
  logic signed [OP_W:0] mulB;

  function automatic logic signed [OP_W:0] condition(input logic [OP_W-1:0] raw,
                                                     input fmtT f, input logic w);
    logic [OP_W-1:0] sel;
    logic            topBit;
    if (w) begin
      sel = raw;
    end else if (f == FMT_FRAC) begin
      sel = {raw[NARROW_W-1:0], {GAP{1'b0}}};
    end else if (f == FMT_UINT) begin
      sel = {{GAP{1'b0}}, raw[NARROW_W-1:0]};
    end else begin
      sel = {{GAP{raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
    end
    topBit = (f == FMT_UINT) ? 1'b0 : sel[OP_W-1];
    return {topBit, sel};
  endfunction

  always_comb begin
    mulA = condition(opA, fmt, wide);
    mulB = condition(opB, fmt, wide);
  end

  // stage 1: full product and its mode fields
  logic signed [PROD_FULL-1:0] prodNow;
  logic [PROD_FULL-1:0]        prodQ;
  fmtT                         fmtQ;
  logic                        rndQ;
  shiftT                       shfQ;
  logic                        subQ;
  logic                        satQ;

  assign prodNow = PROD_FULL'(mulA) * PROD_FULL'(mulB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ <= '0;
      fmtQ  <= FMT_SINT;
      rndQ  <= 1'b0;
      shfQ  <= SH_NONE;
      subQ  <= 1'b0;
      satQ  <= 1'b0;
    end else if (strobes.capture) begin
      prodQ <= prodNow;
      fmtQ  <= fmt;
      rndQ  <= rnd;
      shfQ  <= shf;
      subQ  <= sub;
      satQ  <= sat;
    end
  end

  // stage 2: reduce, extend, scale
  logic [ACC_W-1:0] scaledProd;

  mac_reduce #(
    .PROD_FULL(PROD_FULL),
    .PROD_W   (PROD_W),
    .ACC_W    (ACC_W)
  ) i_reduce (
    .prod  (prodQ),
    .fmt   (fmtQ),
    .rnd   (rndQ),
    .shf   (shfQ),
    .scaled(scaledProd)
  );

  // add / subtract with overflow handling
  logic [ACC_W-1:0] accQ;
  logic             unsMode;
  logic [SUM_W-1:0] accExt;
  logic [SUM_W-1:0] prodExt;
  logic [SUM_W-1:0] sumRaw;
  logic             ovfNow;
  logic [ACC_W-1:0] clampVal;
  logic [ACC_W-1:0] nextAcc;

  always_comb begin
    unsMode = (fmtQ == FMT_UINT);
    accExt  = {(unsMode ? 1'b0 : accQ[ACC_W-1]), accQ};
    prodExt = {(unsMode ? 1'b0 : scaledProd[ACC_W-1]), scaledProd};
    sumRaw  = subQ ? (accExt - prodExt) : (accExt + prodExt);
    if (unsMode) begin
      ovfNow   = sumRaw[SUM_W-1];
      clampVal = subQ ? '0 : '1;
    end else begin
      ovfNow   = sumRaw[SUM_W-1] ^ sumRaw[ACC_W-1];
      clampVal = sumRaw[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                 : {1'b0, {(ACC_W-1){1'b1}}};
    end
    nextAcc = (ovfNow && satQ) ? clampVal : sumRaw[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   accQ <= '0;
    else if (strobes.clear)      accQ <= '0;
    else if (strobes.load)       accQ <= loadVal;
    else if (strobes.accumulate) accQ <= nextAcc;
  end

  assign accOut = accQ;
  assign ovfDet = ovfNow;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (accOut == '0)); // R12

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (accOut == $past(loadVal))); // R12

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.clear || strobes.load || strobes.accumulate) |=> $stable(accOut)); // R1

  AST_NO_WRAP_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accumulate && satQ && ovfNow && unsMode && !subQ) |=> (accOut == '1)); // R9

endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
#(
  parameter int OP_W     = 32,
  parameter int NARROW_W = 16,
  parameter int PROD_W   = 40,
  parameter int ACC_W    = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic [1:0]       opFmt,
  input  logic             opWide,
  input  logic             roundEn,
  input  logic [1:0]       prodShift,
  input  logic             subEn,
  input  logic             satEn,
  input  logic             loadEn,
  input  logic [ACC_W-1:0] loadVal,
  input  logic             clearEn,
  output logic [ACC_W-1:0] accOut,
  output logic             accValid,
  output logic             ovfFlag
);

  strobeT strobes;
  logic   ovfDet;

  mac_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .loadEn  (loadEn),
    .clearEn (clearEn),
    .ovfDet  (ovfDet),
    .strobes (strobes),
    .accValid(accValid),
    .ovfFlag (ovfFlag)
  );

  mac_datapath #(
    .OP_W    (OP_W),
    .NARROW_W(NARROW_W),
    .PROD_W  (PROD_W),
    .ACC_W   (ACC_W)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .fmt    (fmtT'(opFmt)),
    .wide   (opWide),
    .rnd    (roundEn),
    .shf    (shiftT'(prodShift)),
    .sub    (subEn),
    .sat    (satEn),
    .loadVal(loadVal),
    .accOut (accOut),
    .ovfDet (ovfDet)
  );

endmodule

// File: tb/test_mac_pipe.sv
module test_mac_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [1:0]  opFmt = '0;
  logic        opWide = 1'b0;
  logic        roundEn = 1'b0;
  logic [1:0]  prodShift = '0;
  logic        subEn = 1'b0;
  logic        satEn = 1'b0;
  logic        loadEn = 1'b0;
  logic [47:0] loadVal = '0;
  logic        clearEn = 1'b0;
  logic [47:0] accOut;
  logic        accValid;
  logic        ovfFlag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  mac_pipe i_mac_pipe (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .opFmt(opFmt), .opWide(opWide), .roundEn(roundEn), .prodShift(prodShift),
    .subEn(subEn), .satEn(satEn), .loadEn(loadEn), .loadVal(loadVal),
    .clearEn(clearEn), .accOut(accOut), .accValid(accValid), .ovfFlag(ovfFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // operand value as read by the requirements (R2)
  function automatic logic signed [79:0] opValue(input logic [31:0] x, input logic [1:0] fmt,
                                                  input logic wide);
    if (wide) begin
      if (fmt == 2'b01) return 80'(x);
      return 80'(signed'(x));
    end
    if (fmt == 2'b01) return 80'(x[15:0]);
    if (fmt == 2'b10) return 80'(signed'({x[15:0], 16'h0000}));
    return 80'(signed'(x[15:0]));
  endfunction

  function automatic void modelStep(input logic [47:0] acc, input logic [31:0] a,
      input logic [31:0] b, input logic [1:0] fmt, input logic wide, input logic rnd,
      input logic [1:0] shf, input logic sub, input logic sat,
      output logic [47:0] nxt, output logic ovf);
    logic signed [79:0] pr;
    logic [63:0] t;
    logic [64:0] r;
    logic [39:0] p40;
    logic [47:0] e;
    longint pv;
    longint av;
    longint res;
    longint sMax;
    longint uMax;
    logic uns;
    uns = (fmt == 2'b01);
    pr = opValue(a, fmt, wide) * opValue(b, fmt, wide);
    if (fmt == 2'b10) begin
      t = pr[63:0] << 1;                          // R4
      if (rnd) begin                              // R5
        r = {1'b0, t} + 65'h800000;
        p40 = r[63:24];
        if (t[23:0] == 24'h800000) p40[0] = 1'b0;
      end else begin
        p40 = t[63:24];
      end
    end else begin
      p40 = pr[39:0];                             // R3
    end
    e = uns ? {8'h00, p40} : {{8{p40[39]}}, p40};  // R6
    if (shf == 2'b01) e = e << 1;                 // R7
    else if (shf == 2'b10) e = uns ? (e >> 1) : 48'($signed(e) >>> 1);
    if (uns) begin
      pv = longint'({16'h0, e});
      av = longint'({16'h0, acc});
    end else begin
      pv = longint'($signed(e));
      av = longint'($signed(acc));
    end
    res = sub ? (av - pv) : (av + pv);            // R8
    sMax = (longint'(1) <<< 47) - 1;
    uMax = (longint'(1) <<< 48) - 1;
    if (uns) ovf = (res < 0) || (res > uMax);
    else     ovf = (res > sMax) || (res < -sMax - 1);
    if (ovf && sat) begin                         // R9
      if (uns) nxt = sub ? 48'h0 : 48'hFFFF_FFFF_FFFF;
      else     nxt = (res > 0) ? 48'h7FFF_FFFF_FFFF : 48'h8000_0000_0000;
    end else begin
      nxt = res[47:0];                            // R10
    end
  endfunction

  localparam logic [31:0] OPS [10] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h0000_8000, 32'h0000_FFFF, 32'h1234_5678, 32'h4000_0000, 32'hC000_4003
  };
  localparam logic [47:0] SEEDS [5] = '{
    48'h0000_0000_0000, 48'h7FFF_FFFF_F000, 48'h8000_0000_0100,
    48'hFFFF_FFFF_FF00, 48'h0000_1234_5678
  };

  string tag;

  initial begin
    logic [47:0] expAcc;
    logic        expOvf;
    logic [47:0] cum [24];

    // R13: reset state
    repeat (3) @(negedge clk);
    check("R13 acc in reset", 64'(accOut), 64'h0);
    check("R13 flag in reset", 64'(ovfFlag), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R13 acc after reset", 64'(accOut), 64'h0);
    check("R13 valid after reset", 64'(accValid), 64'h0);

    // sweep of every mode combination over corner operands (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int combo = 0; combo < 72; combo++) begin
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          logic [1:0]  f;
          logic        w;
          logic        rd;
          logic [1:0]  sh;
          logic        sb;
          logic        st;
          logic [47:0] seed;
          f  = 2'(combo % 3);
          w  = combo[0 +: 8] / 3 % 2 == 1;
          rd = (combo / 6) % 2 == 1;
          sh = 2'((combo / 12) % 3);
          sb = (combo / 36) % 2 == 1;
          st = ((i + combo) % 2) == 1;
          seed = SEEDS[(i + j + combo) % 5];
          clearEn = 1'b1;
          @(negedge clk);
          clearEn = 1'b0;
          loadEn = 1'b1;
          loadVal = seed;
          @(negedge clk);
          loadEn = 1'b0;
          inValid = 1'b1;
          opA = OPS[i];
          opB = OPS[j] ^ 32'(combo);
          opFmt = f; opWide = w; roundEn = rd; prodShift = sh; subEn = sb; satEn = st;
          modelStep(seed, opA, opB, f, w, rd, sh, sb, st, expAcc, expOvf);
          @(negedge clk);
          inValid = 1'b0;
          @(negedge clk);
          if (f == 2'b10) tag = rd ? "R5 rounded fraction" : "R4 truncated fraction";
          else if (f == 2'b01) tag = "R6 unsigned accumulate";
          else tag = "R3 signed accumulate";
          check(tag, 64'(accOut), 64'(expAcc));
          check("R11 overflow flag", 64'(ovfFlag), 64'(expOvf));
          check("R1 valid pulse", 64'(accValid), 64'h1);
        end
      end
    end

    // R1: back-to-back stream, one pair per cycle
    clearEn = 1'b1;
    @(negedge clk);
    clearEn = 1'b0;
    begin
      logic [47:0] run;
      logic        dummy;
      run = '0;
      for (int k = 0; k < 20; k++) begin
        modelStep(run, 32'(k * 7919 - 40000), 32'(k + 3), 2'b00, 1'b1, 1'b0, 2'b00,
                  1'b0, 1'b0, run, dummy);
        cum[k] = run;
      end
    end
    for (int k = 0; k < 22; k++) begin
      if (k >= 2) check("R1 streamed sum", 64'(accOut), 64'(cum[k-2]));
      if (k < 20) begin
        inValid = 1'b1;
        opA = 32'(k * 7919 - 40000); opB = 32'(k + 3);
        opFmt = 2'b00; opWide = 1'b1; roundEn = 1'b0; prodShift = 2'b00;
        subEn = 1'b0; satEn = 1'b0;
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end

    // R12: a load overrides an accumulation due on the same edge
    loadEn = 1'b1; loadVal = 48'h0000_0000_1000;
    @(negedge clk);
    loadEn = 1'b0;
    inValid = 1'b1; opA = 32'd5; opB = 32'd6;
    @(negedge clk);
    inValid = 1'b0;
    loadEn = 1'b1; loadVal = 48'h1234_0000_ABCD;
    @(negedge clk);
    loadEn = 1'b0;
    check("R12 load wins", 64'(accOut), 64'h1234_0000_ABCD);
    check("R12 no valid on override", 64'(accValid), 64'h0);
    @(negedge clk);
    check("R12 accumulation dropped", 64'(accOut), 64'h1234_0000_ABCD);

    // R12: clear beats both load and accumulation
    inValid = 1'b1; opA = 32'd9; opB = 32'd9;
    @(negedge clk);
    inValid = 1'b0;
    clearEn = 1'b1; loadEn = 1'b1; loadVal = 48'h5555_5555_5555;
    @(negedge clk);
    clearEn = 1'b0; loadEn = 1'b0;
    check("R12 clear wins", 64'(accOut), 64'h0);

    // R11: flag persists through later clean accumulations, drops on clear
    loadEn = 1'b1; loadVal = 48'h7FFF_FFFF_FFFF;
    @(negedge clk);
    loadEn = 1'b0;
    inValid = 1'b1; opA = 32'd1; opB = 32'd1; opFmt = 2'b00; opWide = 1'b1;
    prodShift = 2'b00; subEn = 1'b0; satEn = 1'b1;
    @(negedge clk);
    opA = 32'd0;
    @(negedge clk);
    check("R9 signed clamp high", 64'(accOut), 64'h7FFF_FFFF_FFFF);
    check("R11 flag set", 64'(ovfFlag), 64'h1);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 flag held", 64'(ovfFlag), 64'h1);
    clearEn = 1'b1;
    @(negedge clk);
    clearEn = 1'b0;
    check("R11 flag dropped", 64'(ovfFlag), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule